// File: doc/BRIEF.md
# Four-Lane Sixteen-Tap FIR Filter

The block is a sixteen-tap finite impulse response filter. Each accepted input sample produces one output. Its taps are split across four multiply-accumulate lanes, and each lane has its own bank of four coefficients and its own pipelined multiplier. In every lane issue cycle, each lane takes one coefficient from its own bank and one matching sample from a shared sixteen-entry delay line. The lane multipliers run in parallel. After a lane has accumulated its four products, the four lane sums are added and the result is registered. The whole operation fits in a fixed budget of at most twelve clock cycles from sample acceptance to result.

The producer offers a sample with `in_valid`. The sample is taken only in a cycle where `in_ready` is high, which means the filter is idle. Coefficients are loaded one tap at a time through a write port. A loaded value is used from the next computation onward. The multiplier pipeline depth `MUL_LAT` can be set from 1 to 3, and it fixes the result latency.

Top module: `fir4lane`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_data` is 0. Every coefficient and every delay-line entry is cleared, so the outputs after reset depend only on samples and coefficients loaded after reset.
- R2: For each accepted sample x[n], the result is the signed sum over k = 0..15 of c[k]·x[n−k]. Here c[k] is the coefficient of tap k. Any sample older than those accepted since reset counts as zero. Samples and coefficients are two's complement.
- R3: `coef_addr` is the tap number k. Bits [3:2] select the lane bank and bits [1:0] select the entry within that bank. Tap k always weights the sample accepted k samples before the newest.
- R4: `out_valid` rises exactly MUL_LAT+5 clock edges after the edge that accepts the sample. This is never more than 12, for MUL_LAT of 1, 2 or 3.
- R5: `in_ready` is low from the edge after acceptance up to the cycle in which `out_valid` is high. A sample offered while `in_ready` is low is not taken and does not enter the delay line.
- R6: A coefficient write made while `in_ready` is low is ignored.
- R7: If a coefficient write and an accepted sample occur in the same cycle, the new coefficient is already used for that sample's result.
- R8: The result keeps full precision. With every coefficient at −256 and sixteen samples of −128, the result is 524288.
- R9: `out_valid` is a one-cycle pulse. `out_data` keeps its value until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | DATA_W | Signed input sample |
| in_ready | output | 1 | Filter idle; an offered sample is taken this cycle |
| coef_we | input | 1 | Coefficient write strobe, honoured only while idle |
| coef_addr | input | log2(TAPS) | Tap number to write |
| coef_data | input | COEF_W | Signed coefficient value |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| out_data | output | DATA_W+COEF_W+log2(TAPS) | Signed filter result, held between pulses |

## Verification
Two operations can fall in the same idle cycle: a coefficient write and the acceptance of a sample. The bench provokes this by raising `coef_we` and `in_valid` on the same clock. It then judges the outcome by comparing the result against a model that applies the write before the sample's products. Two collisions with a busy filter are also tested. In one, a write arrives while `in_ready` is low. In the other, a sample is held on the input through the busy window. Each case is judged by the results that follow, which must match a model in which the write never happened and the held sample entered only once.

// File: rtl/fir4lane.sv
module fir4lane #(
  parameter int DATA_W  = 8,
  parameter int COEF_W  = 9,
  parameter int TAPS    = 16,
  parameter int LANES   = 4,
  parameter int MUL_LAT = 2,
  localparam int PER    = TAPS / LANES,
  localparam int AW     = $clog2(TAPS),
  localparam int PW     = $clog2(PER),
  localparam int PROD_W = DATA_W + COEF_W,
  localparam int OUT_W  = PROD_W + $clog2(TAPS),
  localparam int DONE   = MUL_LAT + PER + 1,
  localparam int CW     = $clog2(DONE + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     in_ready,
  input  logic                     coef_we,
  input  logic [AW-1:0]            coef_addr,
  input  logic signed [COEF_W-1:0] coef_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);
  logic                     busy;
  logic [CW-1:0]            cnt;
  logic signed [DATA_W-1:0] dly  [TAPS];
  logic signed [COEF_W-1:0] coef [TAPS];
  logic signed [OUT_W-1:0]  lane_sum [LANES];
  logic signed [OUT_W-1:0]  total;

  wire          accept = in_valid & ~busy;
  wire [PW-1:0] sel    = PW'(cnt - CW'(1));
  wire          take   = busy && (cnt > CW'(MUL_LAT)) && (cnt <= CW'(MUL_LAT + PER));

  assign in_ready = ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < TAPS; k++) begin
        dly[k]  <= '0;
        coef[k] <= '0;
      end
    end else begin
      if (accept) begin
        dly[0] <= in_data;
        for (int k = 1; k < TAPS; k++) dly[k] <= dly[k-1];
      end
      if (coef_we && !busy) coef[coef_addr] <= coef_data;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic signed [PROD_W-1:0] pipe [MUL_LAT];
    logic signed [OUT_W-1:0]  acc;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int s = 0; s < MUL_LAT; s++) pipe[s] <= '0;
        acc <= '0;
      end else begin
        pipe[0] <= coef[l*PER + int'(sel)] * dly[l*PER + int'(sel)];
        for (int s = 1; s < MUL_LAT; s++) pipe[s] <= pipe[s-1];
        if (accept)
          acc <= '0;
        else if (take)
          acc <= acc + {{(OUT_W-PROD_W){pipe[MUL_LAT-1][PROD_W-1]}}, pipe[MUL_LAT-1]};
      end
    end
    assign lane_sum[l] = acc;
  end

  always_comb begin
    total = '0;
    for (int l = 0; l < LANES; l++) total = total + lane_sum[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= CW'(1);
      end else if (busy) begin
        cnt <= cnt + CW'(1);
        if (cnt == CW'(DONE)) begin
          busy      <= 1'b0;
          cnt       <= '0;
          out_valid <= 1'b1;
          out_data  <= total;
        end
      end
    end
  end
endmodule

// File: rtl/fir4lane_chk.sv
module fir4lane_chk #(
  parameter int MUL_LAT = 2,
  parameter int PER     = 4,
  parameter int OUT_W   = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  logic [5:0] since;

  always_ff @(posedge clk) begin
    if (!rst_n) since <= '0;
    else if (in_valid && in_ready) since <= 6'd1;
    else if (!in_ready && since != 6'h3f) since <= since + 6'd1;
  end

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since == 6'(MUL_LAT + PER + 2)));

  // R4
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (since <= 6'd13));

  // R5
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5
  ready_at_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> in_ready);

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
endmodule

bind fir4lane fir4lane_chk #(.MUL_LAT(MUL_LAT), .PER(PER), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/fir4lane_tb_top.sv
module fir4lane_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic signed [7:0] in_data = '0;
  logic              coef_we = 1'b0;
  logic [3:0]        coef_addr = '0;
  logic signed [8:0] coef_data = '0;
  logic              rdy1, rdy2, rdy3, v1, v2, v3;
  logic [20:0]       d1, d2, d3;

  fir4lane #(.MUL_LAT(2)) dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(rdy2), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(v2), .out_data(d2));
  fir4lane #(.MUL_LAT(1)) dut_l1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(rdy1), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(v1), .out_data(d1));
  fir4lane #(.MUL_LAT(3)) dut_l3 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(rdy3), .coef_we(coef_we), .coef_addr(coef_addr), .coef_data(coef_data),
    .out_valid(v3), .out_data(d3));

  localparam int CO[16] = '{5, -3, 100, -256, 255, 0, 7, -1, 12, -50, 33, 1, -128, 64, 9, -77};
  localparam int VEC[18][2] = '{
    '{1, 5}, '{0, -3}, '{0, 100}, '{0, -256}, '{0, 255}, '{0, 0}, '{0, 7}, '{0, -1},
    '{0, 12}, '{0, -50}, '{0, 33}, '{0, 1}, '{0, -128}, '{0, 64}, '{0, 9}, '{0, -77},
    '{0, 0}, '{-2, -10}};

  int checks = 0, fails = 0;
  int mc[16], mx[16];

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model_y();
    int s = 0;
    for (int k = 0; k < 16; k++) s += mc[k] * mx[k];
    return s;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 16; k++) begin mc[k] = 0; mx[k] = 0; end
    @(negedge clk);
  endtask

  task automatic wcoef(int k, int v);
    coef_we = 1'b1; coef_addr = 4'(k); coef_data = 9'(v);
    @(negedge clk);
    coef_we = 1'b0;
    mc[k] = v;
  endtask

  // stray: cycles a second sample stays offered while busy; bw: write during busy;
  // sk >= 0: coefficient write to tap sk with value sv in the accepting cycle
  task automatic send(int x, int stray, bit bw, int sk, int sv, string tag);
    int n1 = 0, n2 = 0, n3 = 0;
    in_valid = 1'b1; in_data = 8'(x);
    if (sk >= 0) begin
      coef_we = 1'b1; coef_addr = 4'(sk); coef_data = 9'(sv); mc[sk] = sv;
    end
    for (int k = 15; k > 0; k--) mx[k] = mx[k-1];
    mx[0] = x;
    @(negedge clk);
    coef_we = 1'b0;
    in_data = 8'sd99;
    in_valid = (stray > 0);
    for (int n = 1; n <= 16; n++) begin
      if (n == 1) chk("R5 ready low after take", rdy2, 0);
      if (n == stray + 1) in_valid = 1'b0;
      if (bw && n == 2) begin coef_we = 1'b1; coef_addr = 4'd0; coef_data = 9'sd200; end
      if (bw && n == 3) coef_we = 1'b0;
      if (v1 && n1 == 0) n1 = n;
      if (v2 && n2 == 0) n2 = n;
      if (v3 && n3 == 0) n3 = n;
      if (n2 != 0 && n == n2 + 1) chk("R9 single-cycle pulse", v2, 0);
      if (n3 != 0 && n > n2 + 1) break;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk("R4 latency depth1", n1 - 1, 6);
    chk("R4 latency depth2", n2 - 1, 7);
    chk("R4 latency depth3", n3 - 1, 8);
    chk({tag, " depth2"}, longint'($signed(d2)), model_y());
    chk({tag, " depth1"}, longint'($signed(d1)), model_y());
    chk({tag, " depth3"}, longint'($signed(d3)), model_y());
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 in_ready after reset", rdy2, 1);
    chk("R1 out_valid after reset", v2, 0);
    chk("R1 out_data after reset", longint'($signed(d2)), 0);
    send(5, 0, 0, -1, 0, "R1 zero coefficients");

    do_reset();
    for (int k = 0; k < 16; k++) wcoef(k, CO[k]);
    for (int i = 0; i < 18; i++) begin
      send(VEC[i][0], 0, 0, -1, 0, "R3 impulse table");
      chk("R2 table value", longint'($signed(d2)), VEC[i][1]);
    end

    for (int i = 0; i < 20; i++) send(((i * 29) % 255) - 127, 0, 0, -1, 0, "R2 ramp pattern");

    send(-77, 4, 0, -1, 0, "R5 held sample while busy");
    send(3, 0, 0, -1, 0, "R5 no extra sample entered");
    send(11, 0, 1, -1, 0, "R6 busy write ignored");
    send(-6, 0, 0, -1, 0, "R6 coefficient unchanged");
    send(40, 0, 0, 5, -200, "R7 same-cycle write");
    send(0, 0, 0, 0, 123, "R7 same-cycle write tap0");

    do_reset();
    for (int k = 0; k < 16; k++) wcoef(k, -256);
    for (int i = 0; i < 16; i++) send(-128, 0, 0, -1, 0, "R8 extremes");
    chk("R8 full precision", longint'($signed(d2)), 524288);
    repeat (3) @(negedge clk);
    chk("R9 result held", longint'($signed(d2)), 524288);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule